// File: doc/BRIEF.md
# Synchronous Serial Port Core

This block is the data path of a memory-mapped synchronous serial port. Software programs a word size and a few control bits, then writes words into an eight-entry transmit queue through a single data register. A transfer engine takes each queued word and does one of three things with it. In loopback it copies the word back into the eight-entry receive queue. With a shifter attached it trades the word for the shifter's reply over a valid/acknowledge word port. With no shifter attached it stores zero in its place. Software then reads the received words back through the same data register.

The engine never lets the receive queue overflow. When that queue is full, the engine waits and holds the pending transmit word. It resumes on its own once a read frees space. Status flags and the two interrupt sources come straight from the queue occupancies, with thresholds at half depth. A fixed block of identification bytes sits at the top of the 4 KiB window. The register bus is single-cycle and uses word addresses. Read data is combinational, and a read of the data register pops the receive queue at the clock edge that ends the access.

Top module: `ssp_core`

## Requirements
- R1: After reset both queues are empty. The interrupt mask reads 0, the status register reads 0x03, the raw interrupt register reads 0x08 and `irq` is low.
- R2: The transmit queue holds 8 words. A data-register write (word address 2) while it holds 8 words is discarded and never reaches the receive side.
- R3: A data-register read while the receive queue is empty returns 0 and changes no state.
- R4: Bits [3:0] of control 0 (word address 0) set the word size n+1. The mask (2^(n+1))-1 is applied to every word entering the transmit queue and to every word stored into the receive queue.
- R5: Control 1 (word address 1) bit0 selects loopback and bit1 enables the engine. In loopback with the engine enabled, words move from transmit to receive in order, one per clock.
- R6: With the enable bit clear, no word leaves the transmit queue and `xch_valid` stays low.
- R7: When the receive queue holds 8 words, the engine stalls and keeps its transmit words. Each data-register read lets exactly one more word through, and order is preserved.
- R8: Outside loopback with `link_attached` high, `xch_valid` is raised with the masked head word on `xch_wdata`. The cycle in which `xch_ack` is high stores `xch_rdata` (masked) into the receive queue and retires the transmit word.
- R9: Outside loopback with `link_attached` low, each transmitted word is stored as 0.
- R10: Status (word address 3, read-only) has these bits: bit0 transmit queue empty, bit1 transmit queue not full, bit2 receive queue not empty, bit3 receive queue full, bit4 busy (transmit queue not empty).
- R11: Raw interrupts (word address 6) are bit2 = receive count >= 4 and bit3 = transmit count <= 4. Mask is at word address 5, masked status at word address 7 equals raw AND mask, and `irq` is high when masked status is nonzero.
- R12: The prescaler (word address 4) keeps only its low 8 bits. DMA control (word address 8) and unmapped addresses read 0, and writes to read-only or unmapped addresses change nothing.
- R13: Word addresses 0x3F8 to 0x3FF read the bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word address within the 4 KiB window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| irq | output | 1 | Combined interrupt |
| link_attached | input | 1 | An external shifter is present |
| xch_valid | output | 1 | A transmit word is offered to the shifter |
| xch_wdata | output | 16 | Offered transmit word |
| xch_ack | input | 1 | Shifter returns a word this cycle |
| xch_rdata | input | 16 | Word returned by the shifter |

## Verification
The bench fills the receive queue in loopback and then pushes eight more words plus one extra. A design that overflows would lose or reorder words. A design that keeps the extra word would return it where the bench expects 0 from an empty read. Both mask paths are exercised: a 16-bit value is written at the 8-bit size, and a shifter reply of 0xFFFF is returned at the same size. A design that masks only one side would show the upper byte. The bench steps the occupancies across the half-depth thresholds in both directions, so an off-by-one threshold shows up as a wrong raw interrupt or `irq` level. It also holds transmit data with the enable bit clear, and a design that ignores the enable would drain the queue early.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int CR0_W = 16;
  localparam int CR1_W = 4;
  localparam int PSC_W = 8;
  localparam int INT_W = 4;

  // word addresses of the register map
  localparam logic [9:0] A_CTL0 = 10'd0;
  localparam logic [9:0] A_CTL1 = 10'd1;
  localparam logic [9:0] A_DATA = 10'd2;
  localparam logic [9:0] A_STAT = 10'd3;
  localparam logic [9:0] A_PSC  = 10'd4;
  localparam logic [9:0] A_MASK = 10'd5;
  localparam logic [9:0] A_RAW  = 10'd6;
  localparam logic [9:0] A_MIS  = 10'd7;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h22;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign do_push = push && (cnt_q != FULL);
  assign do_pop  = pop && (cnt_q != '0);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (do_push || do_pop) begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          enable,
  input  logic          loopback,
  input  logic          link_attached,
  input  logic [W-1:0]  word_mask,
  input  logic [W-1:0]  tx_head,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_cnt,
  input  logic          xch_ack,
  input  logic [W-1:0]  xch_rdata,
  output logic          xch_valid,
  output logic [W-1:0]  xch_wdata,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [W-1:0]  rx_word
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic can_move, internal;
  logic [W-1:0] src;

  // a word may move only if there is one to send and room to keep the reply
  assign can_move  = enable && (tx_cnt != '0) && (rx_cnt != FULL);
  assign internal  = loopback || !link_attached;
  assign xch_valid = can_move && !internal;
  assign xch_wdata = tx_head;
  assign tx_pop    = can_move && (internal || xch_ack);
  assign rx_push   = tx_pop;

  always_comb begin
    if (loopback)           src = tx_head;
    else if (link_attached) src = xch_rdata;
    else                    src = '0;
    rx_word = src & word_mask;
  end
endmodule

// File: rtl/ssp_core.sv
module ssp_core #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [9:0]        bus_waddr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              link_attached,
  output logic              xch_valid,
  output logic [DATA_W-1:0] xch_wdata,
  input  logic              xch_ack,
  input  logic [DATA_W-1:0] xch_rdata
);
  import ssp_pkg::*;

  localparam int CW   = $clog2(DEPTH + 1);
  localparam int SZ_W = $clog2(DATA_W);
  localparam logic [CW-1:0]   FULL = CW'(DEPTH);
  localparam logic [CW-1:0]   HALF = CW'(DEPTH / 2);
  localparam logic [SZ_W-1:0] SZ_MAX = SZ_W'(DATA_W - 1);

  logic [CR0_W-1:0] ctl0_q, ctl0_d;
  logic [CR1_W-1:0] ctl1_q, ctl1_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [INT_W-1:0] imask_q, imask_d;
  logic             reg_we;

  logic [DATA_W-1:0] word_mask, tx_head, rx_head, rx_word;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_push, tx_pop, rx_push, rx_pop;
  logic              data_wr, data_rd, port_en;
  logic [4:0]        status;
  logic [INT_W-1:0]  raw_int;

  assign reg_we  = bus_sel && bus_wr;
  assign data_wr = reg_we && (bus_waddr == A_DATA);
  assign data_rd = bus_sel && !bus_wr && (bus_waddr == A_DATA);
  assign port_en = ctl1_q[1];

  always_comb begin
    ctl0_d  = ctl0_q;
    ctl1_d  = ctl1_q;
    psc_d   = psc_q;
    imask_d = imask_q;
    case (bus_waddr)
      A_CTL0:  ctl0_d  = bus_wdata[CR0_W-1:0];
      A_CTL1:  ctl1_d  = bus_wdata[CR1_W-1:0];
      A_PSC:   psc_d   = bus_wdata[PSC_W-1:0];
      A_MASK:  imask_d = bus_wdata[INT_W-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0_q  <= '0;
      ctl1_q  <= '0;
      psc_q   <= '0;
      imask_q <= '0;
    end else if (reg_we) begin
      ctl0_q  <= ctl0_d;
      ctl1_q  <= ctl1_d;
      psc_q   <= psc_d;
      imask_q <= imask_d;
    end
  end

  assign word_mask = {DATA_W{1'b1}} >> (SZ_MAX - ctl0_q[SZ_W-1:0]);
  assign tx_push   = data_wr && (tx_cnt != FULL);
  assign rx_pop    = data_rd && (rx_cnt != '0);

  ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .push_data(bus_wdata & word_mask),
    .pop(tx_pop), .head(tx_head), .count(tx_cnt)
  );

  ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_word),
    .pop(rx_pop), .head(rx_head), .count(rx_cnt)
  );

  ssp_engine #(.W(DATA_W), .DEPTH(DEPTH)) u_eng (
    .enable(port_en), .loopback(ctl1_q[0]), .link_attached(link_attached),
    .word_mask(word_mask), .tx_head(tx_head), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .xch_ack(xch_ack), .xch_rdata(xch_rdata), .xch_valid(xch_valid),
    .xch_wdata(xch_wdata), .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word)
  );

  assign status  = {tx_cnt != '0, rx_cnt == FULL, rx_cnt != '0,
                    tx_cnt != FULL, tx_cnt == '0};
  assign raw_int = {tx_cnt <= HALF, rx_cnt >= HALF, 2'b00};
  assign irq     = |(raw_int & imask_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_waddr[9:3] == 7'h7F) begin
      bus_rdata = DATA_W'(id_byte(bus_waddr[2:0]));
    end else begin
      case (bus_waddr)
        A_CTL0:  bus_rdata = DATA_W'(ctl0_q);
        A_CTL1:  bus_rdata = DATA_W'(ctl1_q);
        A_DATA:  bus_rdata = (rx_cnt != '0) ? rx_head : '0;
        A_STAT:  bus_rdata = DATA_W'(status);
        A_PSC:   bus_rdata = DATA_W'(psc_q);
        A_MASK:  bus_rdata = DATA_W'(imask_q);
        A_RAW:   bus_rdata = DATA_W'(raw_int);
        A_MIS:   bus_rdata = DATA_W'(raw_int & imask_q);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ssp_core_chk.sv
module ssp_core_chk #(
  parameter int DEPTH = 8,
  parameter int DATA_W = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [9:0]        bus_waddr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic              port_en,
  input logic              xch_valid
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  logic data_wr, data_rd;
  assign data_wr = bus_sel && bus_wr && (bus_waddr == 10'd2);
  assign data_rd = bus_sel && !bus_wr && (bus_waddr == 10'd2);

  // R2
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL);

  // R7
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= FULL);

  // R7
  rx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == FULL) && !data_rd |=> rx_cnt == FULL);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en && !data_wr |=> tx_cnt == $past(tx_cnt));

  // R3
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && (rx_cnt == '0) |-> bus_rdata == '0);

  // R8
  xch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xch_valid |-> port_en && (tx_cnt != '0) && (rx_cnt != FULL));
endmodule

bind ssp_core ssp_core_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_waddr(bus_waddr), .bus_rdata(bus_rdata), .tx_cnt(tx_cnt),
  .rx_cnt(rx_cnt), .port_en(port_en), .xch_valid(xch_valid)
);

// File: tb/sim_ssp_core.sv
module sim_ssp_core;
  logic        clk, rst_n, bus_sel, bus_wr, link_attached, xch_ack, irq, xch_valid;
  logic [9:0]  bus_waddr;
  logic [15:0] bus_wdata, bus_rdata, xch_wdata, xch_rdata;
  int errs = 0, checks = 0;
  logic [15:0] cur_mask = 16'hFFFF;
  logic [15:0] exp_q[$];

  ssp_core u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .link_attached(link_attached), .xch_valid(xch_valid), .xch_wdata(xch_wdata),
    .xch_ack(xch_ack), .xch_rdata(xch_rdata));

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [9:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_waddr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic expect_reg(input string req, input logic [9:0] a, input logic [15:0] e);
    logic [15:0] v;
    rd_reg(a, v);
    chk(req, {16'h0, v}, {16'h0, e});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: write a word and record the expected received value
  task automatic push_word(input logic [15:0] d, input bit kept);
    wr_reg(10'd2, d);
    if (kept) exp_q.push_back(d & cur_mask);
  endtask

  task automatic push_expect(input logic [15:0] e);
    exp_q.push_back(e);
  endtask

  // monitor: read one received word and compare with the scoreboard
  task automatic pop_check(input string req);
    logic [15:0] v, e;
    rd_reg(10'd2, v);
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 16'h0;
    chk(req, {16'h0, v}, {16'h0, e});
  endtask

  task automatic set_size(input logic [3:0] n);
    wr_reg(10'd0, {12'h0, n});
    cur_mask = 16'hFFFF >> (4'd15 - n);
  endtask

  // external shifter: wait for an offer, check it, answer once
  task automatic serve(input string req, input logic [15:0] exp_out, input logic [15:0] resp);
    int n = 0;
    while (!xch_valid && n < 50) begin @(negedge clk); n++; end
    chk(req, {31'h0, xch_valid}, 32'h1);
    chk(req, {16'h0, xch_wdata}, {16'h0, exp_out});
    xch_ack = 1; xch_rdata = resp;
    @(negedge clk);
    xch_ack = 0;
  endtask

  bit done = 0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] ids [8];
    ids = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_waddr = 0; bus_wdata = 0;
    link_attached = 0; xch_ack = 0; xch_rdata = 0;
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset state, R10 status layout
    expect_reg("R1 status", 10'd3, 16'h03);
    expect_reg("R1 raw", 10'd6, 16'h08);
    expect_reg("R1 mask", 10'd5, 16'h00);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R12 prescaler, DMA, unmapped, read-only writes
    wr_reg(10'd4, 16'h01A5);
    expect_reg("R12 prescaler", 10'd4, 16'h00A5);
    expect_reg("R12 dma", 10'd8, 16'h0);
    expect_reg("R12 unmapped", 10'd9, 16'h0);
    wr_reg(10'd3, 16'h001F);
    wr_reg(10'd9, 16'hFFFF);
    expect_reg("R12 ro status", 10'd3, 16'h03);

    // R13 identification bytes
    for (int i = 0; i < 8; i++)
      expect_reg("R13 id", 10'h3F8 + 10'(i), {8'h0, ids[i]});

    // R4 transmit-side masking, R5 loopback order
    set_size(4'd7);
    wr_reg(10'd1, 16'h3);
    push_word(16'h1234, 1);
    push_word(16'h00FF, 1);
    idle(2);
    pop_check("R4 tx mask");
    pop_check("R5 loopback");
    // R3 empty read
    expect_reg("R3 empty read", 10'd2, 16'h0);
    expect_reg("R3 status unchanged", 10'd3, 16'h03);

    // R6 disabled engine holds data
    set_size(4'd15);
    wr_reg(10'd1, 16'h1);
    push_word(16'hA001, 1); push_word(16'hA002, 1); push_word(16'hA003, 1);
    idle(3);
    expect_reg("R6 held status", 10'd3, 16'h12);
    chk("R6 no offer", {31'h0, xch_valid}, 32'h0);
    wr_reg(10'd1, 16'h3);
    idle(4);
    expect_reg("R5 drained status", 10'd3, 16'h07);
    pop_check("R6 order 1"); pop_check("R6 order 2"); pop_check("R6 order 3");

    // R7 stall at full receive queue, R2 drop at full transmit queue
    for (int i = 0; i < 16; i++) push_word(16'hC000 + 16'(i), 1);
    push_word(16'hDEAD, 0);
    idle(2);
    expect_reg("R7 full status", 10'd3, 16'h1C);
    expect_reg("R11 raw full", 10'd6, 16'h04);
    for (int i = 0; i < 16; i++) pop_check("R7 stall order");
    expect_reg("R2 dropped word", 10'd2, 16'h0);

    // R11 interrupt thresholds and masking
    wr_reg(10'd1, 16'h1);
    for (int i = 0; i < 5; i++) push_word(16'h0050 + 16'(i), 1);
    expect_reg("R11 raw tx5", 10'd6, 16'h00);
    wr_reg(10'd5, 16'h000C);
    expect_reg("R11 masked none", 10'd7, 16'h00);
    chk("R11 irq low", {31'h0, irq}, 32'h0);
    wr_reg(10'd1, 16'h3);
    idle(6);
    expect_reg("R11 raw both", 10'd6, 16'h0C);
    expect_reg("R11 masked both", 10'd7, 16'h0C);
    chk("R11 irq high", {31'h0, irq}, 32'h1);
    wr_reg(10'd5, 16'h0004);
    expect_reg("R11 masked rx", 10'd7, 16'h04);
    pop_check("R11 pop"); pop_check("R11 pop");
    expect_reg("R11 raw rx3", 10'd6, 16'h08);
    chk("R11 irq drop", {31'h0, irq}, 32'h0);
    pop_check("R11 pop"); pop_check("R11 pop"); pop_check("R11 pop");
    wr_reg(10'd5, 16'h0);

    // R8 external exchange, R4 receive-side masking
    link_attached = 1;
    set_size(4'd7);
    wr_reg(10'd1, 16'h2);
    wr_reg(10'd2, 16'h1234);
    expect_reg("R8 busy", 10'd3, 16'h12);
    serve("R8 offer", 16'h0034, 16'hFFFF);
    push_expect(16'h00FF);
    idle(1);
    pop_check("R4 rx mask");
    set_size(4'd15);
    wr_reg(10'd2, 16'hBEEF);
    serve("R8 offer 16", 16'hBEEF, 16'h5A5A);
    push_expect(16'h5A5A);
    idle(1);
    pop_check("R8 reply");

    // R9 no partner stores zero
    link_attached = 0;
    wr_reg(10'd2, 16'hABCD);
    idle(2);
    expect_reg("R9 stored", 10'd3, 16'h07);
    expect_reg("R9 zero word", 10'd2, 16'h0);
    expect_reg("R9 popped", 10'd3, 16'h03);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule